// File: doc/BRIEF.md
# Staircase H-Bridge Gate Pattern Generator

This block drives the gates of a single-phase inverter built from a chain of full-bridge cells whose outputs are wired in series. Each cell contributes +1, 0 or -1 unit of voltage. With five cells the sum spans eleven levels, from -5 to +5. Each cell switches at the fundamental frequency only. A phase accumulator sweeps one fundamental period per wrap. Each cell enters the conducting state at its own programmed angle and leaves it at the mirror angle, which gives a quarter-wave-symmetric staircase. The same steps repeat with negative polarity in the second half period.

The angle words are computed elsewhere, for example as harmonic-elimination solutions. Typical values for five cells are 6.57, 18.94, 27.18, 45.14 and 62.24 degrees. The block captures a new angle set only while idle or at the instant the phase wraps. A new set therefore always takes effect at the start of a full period. Besides the twenty gate bits, the block reports the signed level it is currently commanding. All pins are plain control and status signals; there is no streaming interface and no back-pressure.

Top module: `shb_staircase_gen`

## Requirements
- R1: `level` equals the number of active cells when phase bit 31 is 0, and minus that number when it is 1. With five cells it takes the eleven values -5 to +5.
- R2: An active cell in the first half period (phase bit 31 = 0) turns on S1 and S4. For cell k, gates[4k+0] is S1, gates[4k+1] is S2, gates[4k+2] is S3 and gates[4k+3] is S4, so its nibble is 4'b1001.
- R3: An active cell in the second half period (phase bit 31 = 1) turns on S2 and S3, which is nibble 4'b0110.
- R4: An inactive cell of a running block turns on S3 and S4 (4'b1100) in the first half period, and S1 and S2 (4'b0011) in the second half period.
- R5: With h = phase[30:0] and a = the captured 32-bit angle word of cell k (angles[32k+31:32k]), cell k is active when a <= h < 2^31 - a. Angle words are below 2^30, where 2^32 stands for 360 degrees.
- R6: On each clock edge with `enable` high, the phase advances by `phase_step` modulo 2^32, starting from 0 at the first enabled edge. The outputs follow the new phase right after that edge.
- R7: Angle words are captured on every edge with `enable` low, and otherwise only on the edge where the phase addition carries out of bit 31. A change at other times has no effect on the outputs until that wrap.
- R8: During reset, and after any edge with `enable` low, the phase is 0, every cell shows 4'b1100 (gates = 20'hCCCCC) and `level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the phase sweep; low holds the block idle |
| phase_step | input | 32 | Phase added per clock (2^32 = one period) |
| angles | input | 160 | Five 32-bit step-in angle words, cell k in bits 32k+31:32k |
| gates | output | 20 | Four switch gates per cell, S1 in the lowest bit |
| level | output | 4 | Signed commanded output level |

## Verification
A corrupted phase register shows at the ports in the very next cycle, because the gates and the level are decoded from it without further delay. Its effect is a step edge at the wrong cycle or a wrong half-period polarity. A wrong captured angle moves one cell's edges throughout a period. If capture happens at the wrong time, the new staircase appears in the middle of a period instead of after the wrap. A mapping fault appears as a cell with the wrong switch pair, or as a level that disagrees with the count of conducting cells.

// File: rtl/shb_pkg.sv
package shb_pkg;

  typedef enum logic [2:0] {
    CELL_OFF,
    CELL_POS,
    CELL_NEG,
    CELL_ZERO_P,
    CELL_ZERO_N
  } cell_mode_t;

  // Nibble order, LSB first: S1, S2, S3, S4
  localparam logic [3:0] NIB_POS    = 4'b1001;
  localparam logic [3:0] NIB_NEG    = 4'b0110;
  localparam logic [3:0] NIB_LOWZ   = 4'b1100;
  localparam logic [3:0] NIB_HIGHZ  = 4'b0011;
  localparam logic [3:0] NIB_IDLE   = NIB_LOWZ;

endpackage

// File: rtl/shb_phase.sv
module shb_phase #(
  parameter int PH_W  = 32,
  parameter int CELLS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [PH_W-1:0]       step,
  input  logic [CELLS*PH_W-1:0] ang_in,
  output logic [PH_W-1:0]       phase,
  output logic                  run,
  output logic [CELLS*PH_W-1:0] ang_q
);

  logic [PH_W:0] sum;
  assign sum = {1'b0, phase} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      run   <= 1'b0;
      ang_q <= '0;
    end else if (!enable) begin
      phase <= '0;
      run   <= 1'b0;
      ang_q <= ang_in;
    end else begin
      run   <= 1'b1;
      phase <= sum[PH_W-1:0];
      if (sum[PH_W]) ang_q <= ang_in;
    end
  end

  // R6: a running, enabled sweep advances by exactly one step
  p_phase_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run) |=> (phase == $past(phase) + $past(step)));

  // R7: no wrap while enabled means the captured angles stay put
  p_angle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sum[PH_W]) |=> $stable(ang_q));

endmodule

// File: rtl/shb_window.sv
module shb_window #(
  parameter int PH_W  = 32,
  parameter int CELLS = 5
) (
  input  logic [PH_W-1:0]       phase,
  input  logic                  run,
  input  logic [CELLS*PH_W-1:0] ang_q,
  output logic [CELLS-1:0]      active,
  output logic                  neg
);

  localparam logic [PH_W-1:0] HALF = {1'b1, {(PH_W-1){1'b0}}};

  logic [PH_W-1:0] h;
  assign h   = {1'b0, phase[PH_W-2:0]};
  assign neg = phase[PH_W-1];

  for (genvar k = 0; k < CELLS; k++) begin : g_cell_win
    logic [PH_W-1:0] a;
    logic [PH_W-1:0] lim;
    assign a   = ang_q[k*PH_W +: PH_W];
    assign lim = HALF - a;
    assign active[k] = run && (h >= a) && (h < lim);
  end

endmodule

// File: rtl/shb_cell_gate.sv
module shb_cell_gate
  import shb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       active,
  input  logic       neg,
  output logic [3:0] nib
);

  cell_mode_t mode;

  always_comb begin
    if (!run)          mode = CELL_OFF;
    else if (active)   mode = neg ? CELL_NEG : CELL_POS;
    else               mode = neg ? CELL_ZERO_N : CELL_ZERO_P;
  end

  always_comb begin
    case (mode)
      CELL_POS:    nib = NIB_POS;
      CELL_NEG:    nib = NIB_NEG;
      CELL_ZERO_N: nib = NIB_HIGHZ;
      default:     nib = NIB_LOWZ;
    endcase
  end

  // R2: two switches on, never both devices of one leg (S1/S3, S2/S4)
  p_leg_safe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(nib) == 2) && !(nib[0] && nib[2]) && !(nib[1] && nib[3]));

endmodule

// File: rtl/shb_staircase_gen.sv
module shb_staircase_gen
  import shb_pkg::*;
#(
  parameter int PH_W  = 32,
  parameter int CELLS = 5,
  parameter int LVL_W = $clog2(CELLS + 1) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic [PH_W-1:0]            phase_step,
  input  logic [CELLS*PH_W-1:0]      angles,
  output logic [4*CELLS-1:0]         gates,
  output logic signed [LVL_W-1:0]    level
);

  localparam logic [4*CELLS-1:0] IDLE_ALL = {CELLS{NIB_IDLE}};

  logic [PH_W-1:0]       phase;
  logic                  run;
  logic [CELLS*PH_W-1:0] ang_q;
  logic [CELLS-1:0]      active;
  logic                  neg;

  shb_phase #(.PH_W(PH_W), .CELLS(CELLS)) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step(phase_step),
    .ang_in(angles), .phase(phase), .run(run), .ang_q(ang_q)
  );

  shb_window #(.PH_W(PH_W), .CELLS(CELLS)) u_window (
    .phase(phase), .run(run), .ang_q(ang_q), .active(active), .neg(neg)
  );

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    shb_cell_gate u_gate (
      .clk(clk), .rst_n(rst_n), .run(run), .active(active[k]),
      .neg(neg), .nib(gates[4*k +: 4])
    );
  end

  logic [LVL_W-1:0] cnt;
  always_comb begin
    cnt = '0;
    for (int k = 0; k < CELLS; k++) cnt = cnt + LVL_W'(active[k]);
    level = neg ? -$signed(cnt) : $signed(cnt);
  end

  // Checking helpers: polarity counts read back from the gate pattern
  int g_pos;
  int g_neg;
  always_comb begin
    g_pos = 0;
    g_neg = 0;
    for (int k = 0; k < CELLS; k++) begin
      if (gates[4*k +: 4] == NIB_POS) g_pos = g_pos + 1;
      if (gates[4*k +: 4] == NIB_NEG) g_neg = g_neg + 1;
    end
  end

  // R1: reported level agrees with the cells actually driven
  p_level_gates_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) == (g_pos - g_neg));

  // R3: never positive and negative cells at once
  p_one_polarity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !((g_pos > 0) && (g_neg > 0)));

  // R8: an edge with enable low leaves every cell idle at level 0
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((gates == IDLE_ALL) && (level == 0)));

endmodule

// File: tb/test_shb_staircase_gen.sv
module test_shb_staircase_gen;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               enable = 1'b0;
  logic [31:0]        phase_step = '0;
  logic [159:0]       angles = '0;
  logic [19:0]        gates;
  logic signed [3:0]  level;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shb_staircase_gen i_shb_staircase_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .phase_step(phase_step),
    .angles(angles), .gates(gates), .level(level)
  );

  // Bench model of the requirements
  logic [31:0] m_ph = '0;
  logic        m_run = 1'b0;
  logic [31:0] m_ang [5];

  always @(posedge clk) begin
    logic [32:0] s;
    if (!rst_n) begin
      m_ph = '0; m_run = 1'b0;
      for (int k = 0; k < 5; k++) m_ang[k] = '0;
    end else if (!enable) begin
      m_ph = '0; m_run = 1'b0;
      for (int k = 0; k < 5; k++) m_ang[k] = angles[32*k +: 32];
    end else begin
      s = {1'b0, m_ph} + {1'b0, phase_step};
      m_run = 1'b1;
      m_ph = s[31:0];
      if (s[32]) for (int k = 0; k < 5; k++) m_ang[k] = angles[32*k +: 32];
    end
  end

  function automatic logic [31:0] deg2w(real d);
    return 32'(longint'(d * 4294967296.0 / 360.0));
  endfunction

  function automatic bit exp_act(int k);
    longint h = longint'(m_ph[30:0]);
    longint a = longint'(m_ang[k]);
    return m_run && (h >= a) && (h < (64'sd2147483648 - a));
  endfunction

  function automatic logic [3:0] exp_nib(int k);
    if (!m_run) return 4'b1100;
    if (exp_act(k)) return m_ph[31] ? 4'b0110 : 4'b1001;
    return m_ph[31] ? 4'b0011 : 4'b1100;
  endfunction

  function automatic int exp_level();
    int n = 0;
    for (int k = 0; k < 5; k++) if (exp_act(k)) n++;
    return m_ph[31] ? -n : n;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < 5; k++) begin
      logic [3:0] e = exp_nib(k);
      string tag;
      if (!m_run)            tag = "R8 cell";
      else if (e == 4'b1001) tag = "R2 cell";
      else if (e == 4'b0110) tag = "R3 cell";
      else                   tag = "R4 R5 cell";
      check($sformatf("%s %0d", tag, k), int'(gates[4*k +: 4]), int'(e));
    end
    check("R1 R5 R6 level", int'(level), exp_level());
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_angles(int sel);
    real d [5];
    if (sel == 0) d = '{6.57, 18.94, 27.18, 45.14, 62.24};
    else if (sel == 1) d = '{10.0, 20.0, 30.0, 40.0, 50.0};
    else d = '{0.0, 0.0, 0.0, 0.0, 0.0};
    for (int k = 0; k < 5; k++) angles[32*k +: 32] = deg2w(d[k]);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // step[63:32], cycles[31:16], angle set[15:0]
  localparam logic [63:0] VEC [4] = '{
    {32'd4294967,  16'd2100, 16'd0},
    {32'd42949673, 16'd350,  16'd1},
    {32'h2000_0000, 16'd40,  16'd0},
    {32'd0,        16'd20,   16'd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    // R8: reset state
    check("R8 reset gates", int'(gates), 20'hCCCCC);
    check("R8 reset level", int'(level), 0);
    rst_n = 1'b1;
    tick();
    check("R8 idle gates", int'(gates), 20'hCCCCC);

    // Table walk; angle changes between rows occur mid-period (R7 in model)
    foreach (VEC[i]) begin
      phase_step = VEC[i][63:32];
      set_angles(int'(VEC[i][15:0]));
      enable = 1'b1;
      for (int c = 0; c < int'(VEC[i][31:16]); c++) begin
        tick();
        check_all();
      end
    end

    // R8: disable mid-run returns to idle right after the edge
    enable = 1'b0;
    tick();
    check("R8 disable gates", int'(gates), 20'hCCCCC);
    check("R8 disable level", int'(level), 0);

    // R7: directed mid-period angle update
    set_angles(0);
    phase_step = 32'd4294967;
    tick();
    enable = 1'b1;
    repeat (100) tick();
    check("R7 before update level", int'(level), 3);
    set_angles(2);
    repeat (50) tick();
    check("R7 old angles kept level", int'(level), 4);
    check_all();
    repeat (950) tick();
    check("R7 after wrap level", int'(level), 5);
    check("R2 all cells positive", int'(gates), 20'h99999);
    repeat (500) tick();
    check("R3 all cells negative level", int'(level), -5);
    check("R3 all cells negative", int'(gates), 20'h66666);

    // R4: zero state alternates pair across half periods
    set_angles(0);
    enable = 1'b0;
    tick();
    enable = 1'b1;
    tick();
    check("R4 positive half zero cell 4", int'(gates[19:16]), 4'b1100);
    repeat (600) tick();
    check("R4 negative half zero cell 4", int'(gates[19:16]), 4'b0011);
    check_all();

    summary();
    $finish;
  end

endmodule